// File: doc/BRIEF.md
# Parallel Port Address/Data Cycle Engine

This block sits on the host side of a parallel port. It gives a small CPU-style register bus two byte-wide registers. One is an address latch and the other is a data latch. When the port is in the enhanced address/data mode, accesses to these registers run address or data cycles on the port pins. Each cycle follows a strobe/wait handshake with the attached peripheral.

A write to either register is accepted only when the mode field selects the enhanced mode and the automatic-transfer bit is clear. Reads are always allowed. A read in the enhanced mode runs a live read cycle, and its response carries the byte fetched from the peripheral. A read in any other mode returns the byte already held in the latch and leaves the pins alone.

A programmable watchdog stops any handshake phase that stalls. It returns the sequencer to idle and raises a sticky flag.

Top module: `epp_host_engine`

## Requirements
- R1: The address latch is at bus offset 3 and the data latch at offset 4. A write to any other offset changes nothing and starts no port activity. A read of any other offset returns 0x00 one cycle after acceptance.
- R2: A write is permitted when `mode_sel` is 3'b100 and `auto_en` is 0. A permitted write stores the byte and starts a write cycle. During that cycle `wr_n` is low, `port_oe` is high and `port_dout` carries the byte. The strobe used is `addr_stb_n` for offset 3 and `data_stb_n` for offset 4.
- R3: In a write or read cycle, the strobe is held off until the synchronised `port_wait` is seen low. The strobe is released once `port_wait` is seen high. `busy` stays high until `port_wait` is seen low again.
- R4: A write made while `mode_sel` is not 3'b100, or while `auto_en` is 1, is accepted and then dropped. No strobe moves, `busy` stays low, and a later read returns the old latch value.
- R5: A read of offset 3 or 4 while `mode_sel` is 3'b100 starts a read cycle, whatever `auto_en` holds. During it `port_oe` is low and `wr_n` is high. `port_din` is captured into the latch when `port_wait` is seen high, and `rsp_valid` returns that byte.
- R6: A read while `mode_sel` is not 3'b100 raises `rsp_valid` exactly one cycle after acceptance, carrying the latched byte. It causes no port activity.
- R7: `busy` is high from the cycle after a cycle starts until the sequencer is idle again. `req_ready` is low while `busy` is high or a live read awaits its response.
- R8: If `port_wait` stays unchanged for `tmo_limit`+1 cycles in any phase, the cycle is aborted and the strobes are released. `tmo_sticky` is then set and stays set until reset. An aborted read returns the latch's previous value.
- R9: After reset the sequencer is idle, both strobes and `wr_n` are high, `port_oe` is low, `tmo_sticky` is 0, `req_ready` is 1 and both latches hold 0x00.
- R10: The two strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 8 | Read response byte |
| mode_sel | input | 3 | Port mode field; 3'b100 selects address/data cycles |
| auto_en | input | 1 | Automatic transfer bit; blocks register writes when 1 |
| tmo_limit | input | 16 | Watchdog limit per handshake phase |
| tmo_sticky | output | 1 | Sticky abort flag |
| busy | output | 1 | Port cycle in progress |
| port_dout | output | 8 | Data lines driven by the host |
| port_oe | output | 1 | Host drives data lines when high |
| port_din | input | 8 | Data lines as seen from the peripheral |
| wr_n | output | 1 | Active-low write line |
| addr_stb_n | output | 1 | Active-low address strobe |
| data_stb_n | output | 1 | Active-low data strobe |
| port_wait | input | 1 | Peripheral wait/ready line (asynchronous) |

## Verification
The bench holds `port_wait` high before a write and checks that the strobe does not move. A design that strobes too early would assert it at once. It then steps the wait line by hand and checks that `busy` outlives the strobe release, which catches an engine that ends the cycle before the peripheral finishes. A peripheral that never answers must abort the cycle, return the old byte and keep the flag set across a later good cycle. A design whose flag is not sticky, or which returns a stale capture, shows a wrong flag or a wrong byte. The table also mixes offsets, modes and the automatic bit. This exposes a decoder that lets a blocked write through, starts a live read outside the enhanced mode, or answers an unmapped offset with latch contents.

// File: rtl/epp_pkg.sv
// Shared types for the parallel port cycle engine.
package epp_pkg;
    // Handshake phases of one port cycle.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;
endpackage

// File: rtl/epp_sync.sv
// Input synchroniser for the asynchronous wait line.
// Assumes STAGES >= 1; output lags the input by STAGES clocks.
module epp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Shift the sampled line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                sr[i] <= sr[i-1];
            end
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/epp_seq.sv
// Strobe/wait handshake sequencer with a per-phase watchdog.
// Assumes wait_s is already synchronised and start only pulses while idle.
module epp_seq
    import epp_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_rd,
    input  logic          start_sel,
    input  logic [DW-1:0] start_byte,
    input  logic          wait_s,
    input  logic [DW-1:0] port_din,
    input  logic [TW-1:0] tmo_limit,
    output logic          idle,
    output logic          done,
    output logic          cap_valid,
    output logic          cap_sel,
    output logic [DW-1:0] cap_byte,
    output logic          tmo_flag,
    output logic [DW-1:0] port_dout,
    output logic          port_oe,
    output logic          wr_n,
    output logic          addr_stb_n,
    output logic          data_stb_n
);
    phase_t        ph;
    logic          rd_q;
    logic          sel_q;
    logic [DW-1:0] byte_q;
    logic [TW-1:0] cnt;
    logic          tmo_q;
    logic          done_q;
    logic          expired;

    // Watchdog limit reached in the current phase.
    assign expired = (cnt == tmo_limit);

    // Phase progression, watchdog counting and sticky abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            rd_q   <= 1'b0;
            sel_q  <= 1'b0;
            byte_q <= '0;
            cnt    <= '0;
            tmo_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph     <= PH_SETUP;
                        rd_q   <= start_rd;
                        sel_q  <= start_sel;
                        byte_q <= start_byte;
                        cnt    <= '0;
                    end
                end
                PH_SETUP: begin
                    if (!wait_s) begin
                        ph  <= PH_STROBE;
                        cnt <= '0;
                    end else if (expired) begin
                        ph     <= PH_IDLE;
                        tmo_q  <= 1'b1;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (wait_s) begin
                        ph  <= PH_HOLD;
                        cnt <= '0;
                    end else if (expired) begin
                        ph     <= PH_IDLE;
                        tmo_q  <= 1'b1;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (!wait_s) begin
                        ph     <= PH_IDLE;
                        done_q <= 1'b1;
                    end else if (expired) begin
                        ph     <= PH_IDLE;
                        tmo_q  <= 1'b1;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Pin levels and capture strobe decoded from the current phase.
    always_comb begin
        idle       = (ph == PH_IDLE);
        port_oe    = !idle && !rd_q;
        wr_n       = !( !idle && !rd_q );
        addr_stb_n = !((ph == PH_STROBE) && !sel_q);
        data_stb_n = !((ph == PH_STROBE) &&  sel_q);
        port_dout  = byte_q;
        cap_valid  = (ph == PH_STROBE) && rd_q && wait_s;
        cap_sel    = sel_q;
        cap_byte   = port_din;
        done       = done_q;
        tmo_flag   = tmo_q;
    end
endmodule

// File: rtl/epp_regs.sv
// Register decode, mode qualification, latches and bus responses.
// Assumes the sequencer accepts start only while idle (guaranteed by req_ready).
module epp_regs #(
    parameter int                DW       = 8,
    parameter int                AW       = 3,
    parameter int                MODE_W   = 3,
    parameter logic [AW-1:0]     ADDR_OFS = 3'd3,
    parameter logic [AW-1:0]     DATA_OFS = 3'd4,
    parameter logic [MODE_W-1:0] EPP_MODE = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              auto_en,
    input  logic              seq_idle,
    input  logic              seq_done,
    input  logic              cap_valid,
    input  logic              cap_sel,
    input  logic [DW-1:0]     cap_byte,
    output logic              start,
    output logic              start_rd,
    output logic              start_sel,
    output logic [DW-1:0]     start_byte
);
    logic [DW-1:0] areg, dreg;
    logic          pend, pend_sel;
    logic          rsp_v;
    logic [DW-1:0] rsp_d;
    logic          accept, hit_a, hit_d, live_mode;
    logic          wr_ok, rd_live, rd_local;

    // Request qualification against offset, mode field and auto bit.
    always_comb begin
        req_ready  = seq_idle && !pend;
        accept     = req_valid && req_ready;
        hit_a      = (req_addr == ADDR_OFS);
        hit_d      = (req_addr == DATA_OFS);
        live_mode  = (mode_sel == EPP_MODE);
        wr_ok      = accept && req_write && (hit_a || hit_d) && live_mode && !auto_en;
        rd_live    = accept && !req_write && (hit_a || hit_d) && live_mode;
        rd_local   = accept && !req_write && !rd_live;
        start      = wr_ok || rd_live;
        start_rd   = rd_live;
        start_sel  = hit_d;
        start_byte = req_wdata;
    end

    // Latch updates, pending live read and response generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            areg     <= '0;
            dreg     <= '0;
            pend     <= 1'b0;
            pend_sel <= 1'b0;
            rsp_v    <= 1'b0;
            rsp_d    <= '0;
        end else begin
            rsp_v <= 1'b0;
            if (wr_ok) begin
                if (hit_d) dreg <= req_wdata;
                else       areg <= req_wdata;
            end
            if (cap_valid) begin
                if (cap_sel) dreg <= cap_byte;
                else         areg <= cap_byte;
            end
            if (rd_live) begin
                pend     <= 1'b1;
                pend_sel <= hit_d;
            end
            if (rd_local) begin
                rsp_v <= 1'b1;
                rsp_d <= hit_a ? areg : (hit_d ? dreg : '0);
            end
            if (pend && seq_done) begin
                pend  <= 1'b0;
                rsp_v <= 1'b1;
                rsp_d <= pend_sel ? dreg : areg;
            end
        end
    end

    assign rsp_valid = rsp_v;
    assign rsp_rdata = rsp_d;
endmodule

// File: rtl/epp_host_engine.sv
// Top of the parallel port address/data cycle engine.
// Assumes port_wait is asynchronous (synchronised here) and port_din is
// stable while the peripheral holds wait high.
module epp_host_engine #(
    parameter int                DW          = 8,
    parameter int                AW          = 3,
    parameter int                MODE_W      = 3,
    parameter int                TW          = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [AW-1:0]     ADDR_OFS    = 3'd3,
    parameter logic [AW-1:0]     DATA_OFS    = 3'd4,
    parameter logic [MODE_W-1:0] EPP_MODE    = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              auto_en,
    input  logic [TW-1:0]     tmo_limit,
    output logic              tmo_sticky,
    output logic              busy,
    output logic [DW-1:0]     port_dout,
    output logic              port_oe,
    input  logic [DW-1:0]     port_din,
    output logic              wr_n,
    output logic              addr_stb_n,
    output logic              data_stb_n,
    input  logic              port_wait
);
    logic          wait_s;
    logic          seq_idle, seq_done;
    logic          cap_valid, cap_sel;
    logic [DW-1:0] cap_byte;
    logic          start, start_rd, start_sel;
    logic [DW-1:0] start_byte;

    epp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (port_wait),
        .q     (wait_s)
    );

    epp_regs #(
        .DW(DW), .AW(AW), .MODE_W(MODE_W),
        .ADDR_OFS(ADDR_OFS), .DATA_OFS(DATA_OFS), .EPP_MODE(EPP_MODE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mode_sel   (mode_sel),
        .auto_en    (auto_en),
        .seq_idle   (seq_idle),
        .seq_done   (seq_done),
        .cap_valid  (cap_valid),
        .cap_sel    (cap_sel),
        .cap_byte   (cap_byte),
        .start      (start),
        .start_rd   (start_rd),
        .start_sel  (start_sel),
        .start_byte (start_byte)
    );

    epp_seq #(.DW(DW), .TW(TW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_rd   (start_rd),
        .start_sel  (start_sel),
        .start_byte (start_byte),
        .wait_s     (wait_s),
        .port_din   (port_din),
        .tmo_limit  (tmo_limit),
        .idle       (seq_idle),
        .done       (seq_done),
        .cap_valid  (cap_valid),
        .cap_sel    (cap_sel),
        .cap_byte   (cap_byte),
        .tmo_flag   (tmo_sticky),
        .port_dout  (port_dout),
        .port_oe    (port_oe),
        .wr_n       (wr_n),
        .addr_stb_n (addr_stb_n),
        .data_stb_n (data_stb_n)
    );

    assign busy = !seq_idle;
endmodule

// File: rtl/epp_host_engine_chk.sv
// Protocol checker for epp_host_engine, attached by bind below.
module epp_host_engine_chk #(
    parameter int                MODE_W   = 3,
    parameter logic [MODE_W-1:0] EPP_MODE = 3'b100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic [MODE_W-1:0] mode_sel,
    input logic              auto_en,
    input logic              rsp_valid,
    input logic              busy,
    input logic              wr_n,
    input logic              port_oe,
    input logic              addr_stb_n,
    input logic              data_stb_n,
    input logic              tmo_sticky
);
    // R10: never both strobes active.
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!addr_stb_n && !data_stb_n));

    // R2: host drives the data lines whenever the write line is low.
    assert_write_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> port_oe);

    // R9: idle port keeps every control line inactive.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (addr_stb_n && data_stb_n && wr_n && !port_oe));

    // R7: no new request is taken while a cycle runs.
    assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R4: a blocked write leaves the port idle.
    assert_blocked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && ((mode_sel != EPP_MODE) || auto_en))
        |=> !busy);

    // R6: a read outside the live mode answers next cycle with no port cycle.
    assert_local_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && (mode_sel != EPP_MODE))
        |=> (rsp_valid && !busy));

    // R8: abort flag is sticky.
    assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_sticky |=> tmo_sticky);
endmodule

bind epp_host_engine epp_host_engine_chk #(
    .MODE_W(MODE_W), .EPP_MODE(EPP_MODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .mode_sel   (mode_sel),
    .auto_en    (auto_en),
    .rsp_valid  (rsp_valid),
    .busy       (busy),
    .wr_n       (wr_n),
    .port_oe    (port_oe),
    .addr_stb_n (addr_stb_n),
    .data_stb_n (data_stb_n),
    .tmo_sticky (tmo_sticky)
);

// File: tb/tb_epp_host_engine.sv
`timescale 1ns/1ps
module tb_epp_host_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [2:0]  mode_sel = 3'd0;
    logic        auto_en = 1'b0;
    logic [15:0] tmo_limit = 16'd1000;
    logic        tmo_sticky, busy, port_oe, wr_n, addr_stb_n, data_stb_n;
    logic [7:0]  port_dout;
    logic [7:0]  periph_byte = 8'h00;
    logic        periph_en = 1'b1;
    logic        man_wait = 1'b0;
    logic        p_wait = 1'b0;
    logic        port_wait;
    int          strobe_cnt = 0;
    int          both_cnt = 0;
    logic [7:0]  seen_byte = 8'h00;
    logic        seen_sel = 1'b0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    assign port_wait = periph_en ? p_wait : man_wait;

    epp_host_engine dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mode_sel(mode_sel), .auto_en(auto_en), .tmo_limit(tmo_limit),
        .tmo_sticky(tmo_sticky), .busy(busy),
        .port_dout(port_dout), .port_oe(port_oe), .port_din(periph_byte),
        .wr_n(wr_n), .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n),
        .port_wait(port_wait)
    );

    // Peripheral model: answers a strobe with wait, records written bytes.
    always @(posedge clk) begin
        p_wait <= (!addr_stb_n || !data_stb_n);
        if (!addr_stb_n || !data_stb_n) begin
            strobe_cnt <= strobe_cnt + 1;
            if (!wr_n) begin
                seen_byte <= port_dout;
                seen_sel  <= !data_stb_n;
            end
        end
        if (!addr_stb_n && !data_stb_n) both_cnt <= both_cnt + 1;
    end

    typedef struct packed {
        logic [2:0] mode;
        logic       aut;
        logic       wr;
        logic [2:0] ofs;
        logic [7:0] wd;
        logic [7:0] pin;
        logic       act;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd4, 1'b0, 1'b1, 3'd3, 8'hA5, 8'h00, 1'b1, 8'hA5},
        '{3'd4, 1'b0, 1'b1, 3'd4, 8'h3C, 8'h00, 1'b1, 8'h3C},
        '{3'd1, 1'b0, 1'b0, 3'd3, 8'h00, 8'h00, 1'b0, 8'hA5},
        '{3'd1, 1'b0, 1'b0, 3'd4, 8'h00, 8'h00, 1'b0, 8'h3C},
        '{3'd4, 1'b1, 1'b1, 3'd3, 8'hFF, 8'h00, 1'b0, 8'h00},
        '{3'd0, 1'b0, 1'b1, 3'd4, 8'h11, 8'h00, 1'b0, 8'h00},
        '{3'd2, 1'b0, 1'b0, 3'd3, 8'h00, 8'h00, 1'b0, 8'hA5},
        '{3'd2, 1'b0, 1'b0, 3'd4, 8'h00, 8'h00, 1'b0, 8'h3C},
        '{3'd4, 1'b0, 1'b0, 3'd3, 8'h00, 8'h5E, 1'b1, 8'h5E},
        '{3'd4, 1'b1, 1'b0, 3'd4, 8'h00, 8'hC3, 1'b1, 8'hC3},
        '{3'd5, 1'b0, 1'b0, 3'd3, 8'h00, 8'h00, 1'b0, 8'h5E},
        '{3'd5, 1'b0, 1'b0, 3'd4, 8'h00, 8'h00, 1'b0, 8'hC3},
        '{3'd4, 1'b0, 1'b1, 3'd2, 8'h77, 8'h00, 1'b0, 8'h00},
        '{3'd3, 1'b0, 1'b0, 3'd2, 8'h00, 8'h00, 1'b0, 8'h00},
        '{3'd4, 1'b0, 1'b0, 3'd5, 8'h00, 8'h00, 1'b0, 8'h00},
        '{3'd4, 1'b0, 1'b1, 3'd4, 8'h00, 8'h00, 1'b1, 8'h00},
        '{3'd6, 1'b0, 1'b0, 3'd4, 8'h00, 8'h00, 1'b0, 8'h00}
    };

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Drive one request; returns at the negedge after it was accepted.
    task automatic bus_req(input logic w, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    task automatic wait_rsp(output bit got, output logic [7:0] val);
        got = 1'b0; val = 8'h00;
        for (int i = 0; i < 300; i++) begin
            if (rsp_valid) begin got = 1'b1; val = rsp_rdata; break; end
            @(negedge clk);
        end
    endtask

    task automatic local_read(input logic [2:0] a, input string tag, input logic [7:0] exp);
        bus_req(1'b0, a, 8'h00);
        check(rsp_valid === 1'b1, tag, int'(rsp_valid), 1);
        check(rsp_rdata === exp, tag, int'(rsp_rdata), int'(exp));
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.ofs != 3'd3 && v.ofs != 3'd4) return "R1";
        if (v.wr) return v.act ? "R2" : "R4";
        return v.act ? "R5" : "R6";
    endfunction

    task automatic check_idle_state(input string tag);
        check(busy === 1'b0, tag, int'(busy), 0);
        check(addr_stb_n === 1'b1 && data_stb_n === 1'b1 && wr_n === 1'b1, tag,
              int'({addr_stb_n, data_stb_n, wr_n}), 7);
        check(port_oe === 1'b0, tag, int'(port_oe), 0);
        check(tmo_sticky === 1'b0, tag, int'(tmo_sticky), 0);
        check(req_ready === 1'b1, tag, int'(req_ready), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog: got hung run expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int s0;
        bit got;
        logic [7:0] val;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state.
        check_idle_state("R9");

        // Vector table walk.
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            string tg;
            v = VECS[k];
            tg = tag_of(v);
            @(negedge clk);
            mode_sel = v.mode; auto_en = v.aut; periph_byte = v.pin;
            s0 = strobe_cnt;
            if (v.wr) begin
                bus_req(1'b1, v.ofs, v.wd);
                if (v.act) begin
                    wait_idle();
                    @(negedge clk);
                    check(seen_byte === v.exp, tg, int'(seen_byte), int'(v.exp));
                    check(seen_sel === (v.ofs == 3'd4), tg, int'(seen_sel), int'(v.ofs == 3'd4));
                end else begin
                    repeat (3) @(negedge clk);
                    check(busy === 1'b0 && strobe_cnt == s0, tg, strobe_cnt - s0, 0);
                end
            end else if (v.act) begin
                bus_req(1'b0, v.ofs, 8'h00);
                wait_rsp(got, val);
                check(got && val === v.exp, tg, int'(val), int'(v.exp));
                check(strobe_cnt > s0, tg, strobe_cnt - s0, 1);
            end else begin
                // R6 also confirms R4: blocked writes left the latch intact.
                local_read(v.ofs, tg, v.exp);
                check(strobe_cnt == s0, tg, strobe_cnt - s0, 0);
            end
        end

        // R3: handshake ordering driven by hand.
        @(negedge clk);
        periph_en = 1'b0; man_wait = 1'b1;
        mode_sel = 3'd4; auto_en = 1'b0; tmo_limit = 16'd1000;
        bus_req(1'b1, 3'd3, 8'h9A);
        repeat (6) @(negedge clk);
        check(addr_stb_n === 1'b1, "R3", int'(addr_stb_n), 1);
        check(busy === 1'b1 && req_ready === 1'b0, "R7", int'({busy, req_ready}), 2);
        man_wait = 1'b0;
        for (int i = 0; i < 10 && addr_stb_n; i++) @(negedge clk);
        check(addr_stb_n === 1'b0, "R3", int'(addr_stb_n), 0);
        check(wr_n === 1'b0 && port_oe === 1'b1 && port_dout === 8'h9A, "R2",
              int'(port_dout), 8'h9A);
        repeat (4) @(negedge clk);
        check(addr_stb_n === 1'b0, "R3", int'(addr_stb_n), 0);
        man_wait = 1'b1;
        for (int i = 0; i < 10 && !addr_stb_n; i++) @(negedge clk);
        check(addr_stb_n === 1'b1, "R3", int'(addr_stb_n), 1);
        repeat (3) @(negedge clk);
        check(busy === 1'b1, "R3", int'(busy), 1);
        man_wait = 1'b0;
        for (int i = 0; i < 10 && busy; i++) @(negedge clk);
        check(busy === 1'b0 && req_ready === 1'b1, "R7", int'({busy, req_ready}), 1);

        // R8: peripheral never answers a read.
        tmo_limit = 16'd10;
        s0 = strobe_cnt;
        periph_byte = 8'hEE;
        bus_req(1'b0, 3'd3, 8'h00);
        wait_rsp(got, val);
        check(got && val === 8'h9A, "R8", int'(val), 8'h9A);
        check(tmo_sticky === 1'b1, "R8", int'(tmo_sticky), 1);
        check(busy === 1'b0 && addr_stb_n === 1'b1, "R8", int'(busy), 0);
        check(strobe_cnt > s0, "R8", strobe_cnt - s0, 1);
        periph_en = 1'b1; tmo_limit = 16'd1000;
        bus_req(1'b1, 3'd4, 8'h55);
        wait_idle();
        @(negedge clk);
        check(seen_byte === 8'h55, "R2", int'(seen_byte), 8'h55);
        check(tmo_sticky === 1'b1, "R8", int'(tmo_sticky), 1);

        // R9: reset clears the flag and both latches.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_state("R9");
        mode_sel = 3'd0;
        local_read(3'd3, "R9", 8'h00);
        local_read(3'd4, "R9", 8'h00);

        // R10: strobes never overlapped during the run.
        check(both_cnt == 0, "R10", both_cnt, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule